// File: doc/BRIEF.md
# Balanced-Ternary Three-Way Branch Decoder

This block decodes one 18-trit instruction word for a balanced-ternary machine. The word arrives as an ordinary signed two's-complement integer, together with the address of the instruction. After a start pulse the block turns the integer into eighteen balanced digits, each in {-1, 0, +1}. It produces one digit per clock, starting with the least significant. It then cuts the digits into fields and checks that the opcode and register fields are legal.

When the opcode is the three-way branch, the block reads one register through a read port. It chooses one of three PC-relative offsets from the sign of that register (negative, zero or positive) and returns the next program counter. The register tested is always the one named in the word, because the machine has no condition register. A selected offset of zero is a fall-through.

Legal opcodes other than the branch just advance the program counter. Illegal opcodes or register fields raise a bad-opcode flag. Integers that no 18-trit word can represent raise a malformed-word flag instead and are not decoded.

Top module: `tern_branch_decoder`

## Requirements
- R1: After reset, `valid`, `taken`, `bad_op` and `bad_word` are 0 and `next_pc` is 0.
- R2: The integer value of a word is op·3^15 + src·3^13 + noff·3^9 + zoff·3^5 + poff. Every field is a balanced digit group: op and zoff/noff span trits 17..15 and 8..5/12..9, src spans trits 14..13, and poff spans trits 4..0. Each field is decoded exactly, including at the extremes ±193710244.
- R3: For the branch opcode (value 5), `reg_idx` presents the src field. The sign of `reg_val` selects the offset: noff if negative, zoff if zero, poff if positive.
- R4: For a branch, `next_pc` = (pc + 1 + selected offset) mod 2^PC_W. `taken` is 1 exactly when the selected offset is nonzero. Offsets reach ±40 (noff, zoff) and ±121 (poff).
- R5: A branch whose selected offset is 0 gives `next_pc` = pc + 1 with `taken` = 0.
- R6: An opcode outside -3..+13 sets `bad_op`, with `taken` = 0 and `next_pc` = pc.
- R7: A src field outside 0..7 (any negative value) sets `bad_op`, with `taken` = 0 and `next_pc` = pc.
- R8: A legal opcode other than the branch gives `next_pc` = pc + 1, with `taken`, `bad_op` and `bad_word` all 0.
- R9: A word above 193710244 or below -193710244 sets `bad_word` (with `bad_op` = 0, `taken` = 0, `next_pc` = pc) and is not decoded.
- R10: Count from the rising edge that samples `start`. `valid` is driven high by the 20th edge after it for a branch, by the 19th for any other decoded word, and by that same edge for a malformed word.
- R11: `start` is ignored while a decode is in progress: the result and its timing belong to the first word.
- R12: `valid` is a single-cycle pulse. `next_pc`, `taken`, `bad_op` and `bad_word` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin decoding `word_in` at `pc_in` |
| word_in | input | 32 | Instruction word, signed two's complement |
| pc_in | input | PC_W | Address of the instruction |
| reg_idx | output | IDX_W | Register read index (src field) |
| reg_val | input | DATA_W | Signed register value for `reg_idx`, combinational |
| valid | output | 1 | One-cycle result strobe |
| next_pc | output | PC_W | Next program counter |
| taken | output | 1 | Branch went to a nonzero offset |
| bad_op | output | 1 | Illegal opcode or register field |
| bad_word | output | 1 | Word outside the 18-trit range |

## Verification
A wrong digit from the serial converter shifts every higher field. It surfaces 20 or 21 cycles after start as a wrong `next_pc`, a misplaced `reg_idx`, or a spurious `bad_op`. Vectors are therefore built from independent field values, so that each field boundary is covered. A converter that leaves a residue after eighteen steps is caught at the decode cycle by an internal check. Timing faults in the state sequence show up as a wrong latency count at the first `valid`. Wrong sign selection shows up as a wrong target, because the three offsets differ and the registers not addressed hold decoy values of the opposite sign.

// File: rtl/tern_branch_decoder.sv
module tern_branch_decoder #(
  parameter int PC_W   = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int BR_OP  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic signed [31:0]       word_in,
  input  logic [PC_W-1:0]          pc_in,
  output logic [IDX_W-1:0]         reg_idx,
  input  logic signed [DATA_W-1:0] reg_val,
  output logic                     valid,
  output logic [PC_W-1:0]          next_pc,
  output logic                     taken,
  output logic                     bad_op,
  output logic                     bad_word
);
  localparam int NTRIT = 18;
  localparam int WMAX  = (3**NTRIT - 1) / 2;
  localparam int CW    = $clog2(NTRIT);
  localparam logic signed [9:0] OP_LO  = -10'sd3;
  localparam logic signed [9:0] OP_HI  = 10'sd13;
  localparam logic signed [9:0] SR_HI  = 10'((2**IDX_W) - 1);
  localparam logic signed [9:0] BR_VAL = 10'(BR_OP);

  typedef enum logic [1:0] {IDLE, CONV, DEC, RD} st_t;
  st_t st;

  logic signed [31:0] q, rem, q_nxt;
  logic signed [1:0]  dig;
  logic [2*NTRIT-1:0] tv;
  logic [CW-1:0]      cnt;
  logic [PC_W-1:0]    pc_q;
  logic signed [9:0]  f_op, f_sr, f_n, f_z, f_p, sel;
  logic               legal, oob;

  assign rem   = q % 32'sd3;
  assign dig   = (rem == 32'sd2 || rem == -32'sd1) ? -2'sd1 :
                 (rem == -32'sd2 || rem == 32'sd1) ?  2'sd1 : 2'sd0;
  assign q_nxt = (q - 32'(dig)) / 32'sd3;
  assign oob   = (word_in > WMAX) || (word_in < -WMAX);

  function automatic logic signed [9:0] tdig(input int i);
    return 10'(signed'(tv[2*i +: 2]));
  endfunction

  always_comb begin
    f_op = '0; f_sr = '0; f_n = '0; f_z = '0; f_p = '0;
    for (int i = 17; i >= 15; i--) f_op = f_op * 10'sd3 + tdig(i);
    for (int i = 14; i >= 13; i--) f_sr = f_sr * 10'sd3 + tdig(i);
    for (int i = 12; i >= 9;  i--) f_n  = f_n  * 10'sd3 + tdig(i);
    for (int i = 8;  i >= 5;  i--) f_z  = f_z  * 10'sd3 + tdig(i);
    for (int i = 4;  i >= 0;  i--) f_p  = f_p  * 10'sd3 + tdig(i);
  end

  assign legal   = (f_op >= OP_LO) && (f_op <= OP_HI) && (f_sr >= 10'sd0) && (f_sr <= SR_HI);
  assign reg_idx = IDX_W'(f_sr);
  assign sel     = reg_val[DATA_W-1] ? f_n : (reg_val == '0) ? f_z : f_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; q <= '0; tv <= '0; cnt <= '0; pc_q <= '0;
      valid <= 1'b0; next_pc <= '0; taken <= 1'b0; bad_op <= 1'b0; bad_word <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (st)
        IDLE: if (start) begin
          pc_q <= pc_in; taken <= 1'b0; bad_op <= 1'b0; bad_word <= 1'b0;
          if (oob) begin
            bad_word <= 1'b1; valid <= 1'b1; next_pc <= pc_in;
          end else begin
            q <= word_in; cnt <= '0; st <= CONV;
          end
        end
        CONV: begin
          tv  <= {dig, tv[2*NTRIT-1:2]};
          q   <= q_nxt;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(NTRIT - 1)) st <= DEC;
        end
        DEC: begin
          if (!legal) begin
            bad_op <= 1'b1; valid <= 1'b1; next_pc <= pc_q; st <= IDLE;
          end else if (f_op != BR_VAL) begin
            valid <= 1'b1; next_pc <= pc_q + 1'b1; st <= IDLE;
          end else begin
            st <= RD;
          end
        end
        RD: begin
          next_pc <= pc_q + 1'b1 + PC_W'(sel);
          taken   <= (sel != 10'sd0);
          valid   <= 1'b1;
          st      <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R12
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) valid |=> !valid);
  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) valid |-> !(bad_op && bad_word));
  // R4
  taken_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && taken) |-> (!bad_op && !bad_word));
  // R2
  residue_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == DEC) |-> (q == 32'sd0));
  // R5
  fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !taken && !bad_op && !bad_word) |-> (next_pc == PC_W'(pc_q + 1'b1)));
  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != IDLE && start) |=> $stable(pc_q));
endmodule

// File: tb/tern_branch_decoder_test.sv
module tern_branch_decoder_test;
  logic clk = 0, rst_n = 0, start = 0;
  logic signed [31:0] word_in = '0;
  logic [15:0] pc_in = '0;
  logic [2:0]  reg_idx;
  logic signed [31:0] reg_val;
  logic valid, taken, bad_op, bad_word;
  logic [15:0] next_pc;
  int regs [8];
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;
  assign reg_val = regs[reg_idx];

  tern_branch_decoder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in), .pc_in(pc_in),
    .reg_idx(reg_idx), .reg_val(reg_val), .valid(valid), .next_pc(next_pc),
    .taken(taken), .bad_op(bad_op), .bad_word(bad_word));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int enc(int op, int sr, int n, int z, int p);
    return op*14348907 + sr*1594323 + n*19683 + z*243 + p;
  endfunction

  // op, src, noff, zoff, poff, pc, register value
  localparam int TV [15][7] = '{
    '{ 5,  1, -40,   3,    7,   100,    -7},
    '{ 5,  2,   9,  40,   -9,  1000,     0},
    '{ 5,  4,   1,   2,  121,    50, 12345},
    '{ 5,  0,   5,   5, -121,    10,     3},
    '{ 5,  3,   0,  11,   12,     7,    -1},
    '{ 5,  4,  -3,  -2,    0, 65535,     8},
    '{ 5,  2,   1,  -1,    1, 65535,     0},
    '{13,  1,   1,   1,    1,    20,     0},
    '{-3,  0,   0,   0,    0,    30,     0},
    '{-4,  0,   2,   2,    2,    40,     0},
    '{-13,-4, -40, -40, -121,   200,     0},
    '{ 5, -1,   4,   4,    4,   300,    -2},
    '{ 5, -4,   4,   4,    4,   301,     2},
    '{13,  4,  40,  40,  121,     0,     0},
    '{ 5,  4,  40, -40,  -50,   500,   -90}
  };

  int k;
  task automatic run(input int w, input int pc);
    @(negedge clk); word_in = w; pc_in = 16'(pc); start = 1;
    @(negedge clk); start = 0; k = 1;
    while (!valid && k < 60) begin @(negedge clk); k++; end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int j = 0; j < 8; j++) regs[j] = 0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 valid", int'(valid), 0);
    chk("R1 taken", int'(taken), 0);
    chk("R1 bad_op", int'(bad_op), 0);
    chk("R1 bad_word", int'(bad_word), 0);
    chk("R1 next_pc", int'(next_pc), 0);
    rst_n = 1;

    for (int v = 0; v < 15; v++) begin
      int op = TV[v][0], sr = TV[v][1], pc = TV[v][5], rv = TV[v][6];
      int off, enpc, etk, ebad, elat;
      bit lg = (op >= -3 && op <= 13 && sr >= 0 && sr <= 7);
      for (int j = 0; j < 8; j++) regs[j] = (rv > 0) ? -5 : 5;
      if (sr >= 0 && sr <= 7) regs[sr] = rv;
      off = (rv < 0) ? TV[v][2] : (rv == 0) ? TV[v][3] : TV[v][4];
      ebad = lg ? 0 : 1; etk = 0; elat = 20;
      if (!lg) enpc = pc;
      else if (op != 5) enpc = (pc + 1) & 16'hFFFF;
      else begin enpc = (pc + 1 + off) & 16'hFFFF; etk = (off != 0); elat = 21; end
      run(enc(op, sr, TV[v][2], TV[v][3], TV[v][4]), pc);
      // R2 R3 R4 R5 R6 R7 R8 R10
      chk($sformatf("R10 latency v%0d", v), k, elat);
      chk($sformatf("R4 next_pc v%0d", v), int'(next_pc), enpc);
      chk($sformatf("R5 taken v%0d", v), int'(taken), etk);
      chk($sformatf("R6 R7 bad_op v%0d", v), int'(bad_op), ebad);
      chk($sformatf("R8 bad_word v%0d", v), int'(bad_word), 0);
      if (lg && op == 5) chk($sformatf("R3 reg_idx v%0d", v), int'(reg_idx), sr);
      @(negedge clk);
      // R12
      chk($sformatf("R12 pulse v%0d", v), int'(valid), 0);
      chk($sformatf("R12 hold v%0d", v), int'(next_pc), enpc);
    end

    // R9 malformed words
    run(193710245, 77);
    chk("R9 bad_word hi", int'(bad_word), 1);
    chk("R9 latency", k, 1);
    chk("R9 bad_op", int'(bad_op), 0);
    chk("R9 next_pc", int'(next_pc), 77);
    run(-193710245, 78);
    chk("R9 bad_word lo", int'(bad_word), 1);
    run(32'sh7fffffff, 79);
    chk("R9 bad_word max", int'(bad_word), 1);
    chk("R9 taken", int'(taken), 0);
    run(-193710244, 80);
    chk("R2 min word decoded", int'(bad_word), 0);
    chk("R6 min word op", int'(bad_op), 1);

    // R11 start during decode ignored
    for (int j = 0; j < 8; j++) regs[j] = -5;
    regs[2] = 9;
    @(negedge clk); word_in = enc(5, 2, 3, 4, 6); pc_in = 16'd1000; start = 1;
    @(negedge clk); start = 0; k = 1;
    repeat (4) begin @(negedge clk); k++; end
    word_in = enc(13, 0, 0, 0, 0); pc_in = 16'd5; start = 1;
    @(negedge clk); start = 0; k++;
    while (!valid && k < 60) begin @(negedge clk); k++; end
    chk("R11 latency", k, 21);
    chk("R11 next_pc", int'(next_pc), 1007);
    chk("R11 taken", int'(taken), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule